// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block connects a simple on-chip request port to an external asynchronous static RAM of 128K bytes. A requester presents a read or a write with a valid/ready handshake. The controller then runs one memory access on the pins: it drives the address, both chip selects (one active low, one active high), the write strobe, the output enable and the tri-state data bus, which is split into an output value, an input value and a drive enable. A read returns its byte through a one-cycle response strobe.

Every access has three phases: setup, strobe and hold. Each phase lasts a whole number of controller clock cycles, set by a parameter, so that the memory's setup, pulse-width and hold minimums are met at the chosen clock rate. Writes are controlled by the write strobe. The address and the write data are held for the entire access. The controller drives the data bus only when the memory's output enable is high. A write that follows a read gets one extra cycle first: in that cycle the output enable is high, the bus is released and both chips are deselected. This gives the memory time to release the bus before the controller drives it.

Top module: `sram_async_ctl`

## Requirements
- R1: During reset and whenever no access is in progress, the pins are idle: `mem_ce_n`=1, `mem_ce`=0, `mem_we_n`=1, `mem_oe_n`=1, `mem_dq_oe`=0. `req_ready` is 1 in this state.
- R2: For a read, both chip selects are active and `mem_we_n` stays 1. `mem_oe_n` is 0 during the setup and strobe phases. The byte on `mem_dq_in` in the last strobe cycle is returned on `rsp_rdata`. `rsp_valid` is 1 for exactly one cycle, SETUP_CYC+PULSE_CYC+1 falling-edge samples after the accepting clock edge.
- R3: For a write, `mem_we_n` is 0 for exactly PULSE_CYC cycles. Before the pulse come SETUP_CYC cycles, and after it come HOLD_CYC cycles, in which both selects are active and `mem_we_n` is 1. The memory captures the byte on the rising edge of `mem_we_n`.
- R4: `mem_addr` and `mem_dq_out` do not change while `mem_we_n` is 0.
- R5: `mem_dq_oe` is 1 only during a write access, and never in a cycle where `mem_oe_n` is 0.
- R6: A write whose previous access was a read is preceded by one turnaround cycle with both selects inactive, `mem_oe_n`=1 and `mem_dq_oe`=0. Its strobe therefore starts one cycle later than it would without the turnaround.
- R7: `req_ready` is 0 from the accepting edge until the access completes. It returns SETUP_CYC+PULSE_CYC+HOLD_CYC+1 samples after acceptance, plus one sample if a turnaround cycle was inserted.
- R8: `rsp_valid` is never asserted for a write.
- R9: Bytes written to the lowest address, the highest address and other addresses read back unchanged. This holds for the data patterns 00, FF, 55, AA and others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle strobe, read byte valid |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 17 | Memory address pins |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_in | input | 8 | Data received from memory |
| mem_dq_oe | output | 1 | Controller data driver enable |

## Verification
All results are counted in falling-edge samples after the clock edge that accepts a request. A read's response is due at sample SETUP_CYC+PULSE_CYC+1. A write's strobe starts at sample SETUP_CYC+1 and lasts PULSE_CYC samples; both move one sample later after a read. `req_ready` returns once the hold phase ends. For each access, the bench records the sample index of each of these events and compares it with the value derived from the parameters given to the bench. It does not wait for an event and then accept whenever it arrives. A behavioural memory model beside the design tracks bus contention and any address change during a write strobe, and these tallies are checked at the end.

// File: rtl/sram_async_ctl.sv
module sram_async_ctl #(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);

  localparam int MAX_AB = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAXC   = (MAX_AB > HOLD_CYC) ? MAX_AB : HOLD_CYC;
  localparam int CW     = (MAXC < 2) ? 1 : $clog2(MAXC);

  typedef enum logic [2:0] {IDLE, TURN, SETUP, ACCESS, HOLD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          wr_q;
  logic          last_rd;
  logic          sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      wr_q      <= 1'b0;
      last_rd   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          wr_q    <= req_write;
          if (req_write && last_rd) begin
            st <= TURN;
          end else begin
            st  <= SETUP;
            cnt <= CW'(SETUP_CYC - 1);
          end
        end
        TURN: begin
          st  <= SETUP;
          cnt <= CW'(SETUP_CYC - 1);
        end
        SETUP: if (cnt == '0) begin
          st  <= ACCESS;
          cnt <= CW'(PULSE_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        ACCESS: if (cnt == '0) begin
          st  <= HOLD;
          cnt <= CW'(HOLD_CYC - 1);
          if (!wr_q) begin
            rsp_rdata <= mem_dq_in;
            rsp_valid <= 1'b1;
          end
        end else begin
          cnt <= cnt - 1'b1;
        end
        HOLD: if (cnt == '0) begin
          st      <= IDLE;
          last_rd <= !wr_q;
        end else begin
          cnt <= cnt - 1'b1;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign sel        = (st == SETUP) || (st == ACCESS) || (st == HOLD);
  assign req_ready  = (st == IDLE);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wdata_q;
  assign mem_ce_n   = !sel;
  assign mem_ce     = sel;
  assign mem_we_n   = !((st == ACCESS) && wr_q);
  assign mem_oe_n   = !(sel && !wr_q && (st != HOLD));
  assign mem_dq_oe  = sel && wr_q;

  // R1
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe));

  // R3
  setup_before_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_ce_n && mem_ce));

  // R3
  hold_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_ce));

  // R4
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> (mem_we_n || $stable(mem_addr)));

  // R4
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |=> (mem_we_n || $stable(mem_dq_out)));

  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R6
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |=> !mem_dq_oe);

  // R2
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  rsp_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_we_n));

endmodule

// File: tb/sram_async_ctl_tb.sv
module sram_async_ctl_tb;
  localparam int S = 2;
  localparam int P = 3;
  localparam int H = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int checks = 0;
  int errors = 0;
  bit prev_rd = 1'b0;

  always #5 clk = ~clk;

  sram_async_ctl #(.SETUP_CYC(S), .PULSE_CYC(P), .HOLD_CYC(H)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce(mem_ce), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe)
  );

  logic [7:0] model [logic [16:0]];
  logic [7:0] exp_mem [logic [16:0]];
  logic [7:0] rd_word;
  logic       mdrv;
  int         contention = 0;
  int         addr_moves = 0;
  logic       pw_low = 1'b0;
  logic [16:0] pa;
  logic [7:0]  pd;

  assign mdrv = !mem_ce_n && mem_ce && !mem_oe_n && mem_we_n;
  always @* rd_word = model.exists(mem_addr) ? model[mem_addr] : 8'hA5;
  assign mem_dq_in = mdrv ? rd_word : 8'h00;

  always @(posedge mem_we_n)
    if (!mem_ce_n && mem_ce) model[mem_addr] = mem_dq_out;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_oe && mdrv) contention++;
      if (pw_low && !mem_we_n && (mem_addr != pa || mem_dq_out != pd)) addr_moves++;
    end
    pw_low = !mem_we_n;
    pa = mem_addr;
    pd = mem_dq_out;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input bit w, input [16:0] a, input [7:0] d, output [7:0] rd);
    int t;
    int we_first = -1, we_cnt = 0, rsp_k = -1, rsp_cnt = 0, ready_k = -1;
    bit turn_ok = 1'b1, oe_ok = 1'b1;
    t = (w && prev_rd) ? 1 : 0;
    rd = 8'h00;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk);
    for (int k = 1; k < 60 && ready_k < 0; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (k == 1 && t == 1)
        turn_ok = mem_ce_n && !mem_ce && mem_oe_n && !mem_dq_oe && mem_we_n;
      if (!mem_we_n) begin
        if (we_first < 0) we_first = k;
        we_cnt++;
      end
      if (mem_dq_oe && (!w || !mem_oe_n)) oe_ok = 1'b0;
      if (rsp_valid) begin
        if (rsp_k < 0) begin rsp_k = k; rd = rsp_rdata; end
        rsp_cnt++;
      end
      if (req_ready) ready_k = k;
    end
    // R7
    chk(ready_k == t + S + P + H + 1, "R7 ready return", ready_k, t + S + P + H + 1);
    // R5
    chk(oe_ok, "R5 driver enable", oe_ok, 1);
    if (w) begin
      // R3 / R6
      chk(we_first == t + S + 1, "R3/R6 strobe start", we_first, t + S + 1);
      chk(we_cnt == P, "R3 strobe width", we_cnt, P);
      // R8
      chk(rsp_cnt == 0, "R8 no response on write", rsp_cnt, 0);
      if (t == 1) chk(turn_ok, "R6 turnaround cycle", turn_ok, 1);
      exp_mem[a] = d;
    end else begin
      // R2
      chk(rsp_k == S + P + 1, "R2 response timing", rsp_k, S + P + 1);
      chk(rsp_cnt == 1, "R2 response width", rsp_cnt, 1);
      chk(we_cnt == 0, "R2 no strobe on read", we_cnt, 0);
    end
    prev_rd = !w;
  endtask

  task automatic read_expect(input [16:0] a, input string tag);
    logic [7:0] r, e;
    e = exp_mem.exists(a) ? exp_mem[a] : 8'hA5;
    run_op(1'b0, a, 8'h00, r);
    chk(r == e, tag, r, e);
  endtask

  task automatic t_reset();
    // R1
    chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe,
        "R1 pins in reset", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    chk(req_ready && !rsp_valid, "R1 ready after reset", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_basic();
    logic [7:0] r;
    run_op(1'b1, 17'h00123, 8'h3C, r);
    read_expect(17'h00123, "R2 basic readback");
    read_expect(17'h00456, "R2 unwritten word");
  endtask

  task automatic t_turnaround();
    logic [7:0] r;
    run_op(1'b0, 17'h00010, 8'h00, r);
    run_op(1'b1, 17'h00011, 8'h5A, r);
    run_op(1'b1, 17'h00012, 8'hC3, r);
    read_expect(17'h00011, "R6 write after read stored");
    read_expect(17'h00012, "R6 back-to-back write stored");
  endtask

  task automatic t_boundary();
    logic [7:0] r;
    run_op(1'b1, 17'h00000, 8'hFF, r);
    run_op(1'b1, 17'h1FFFF, 8'h00, r);
    read_expect(17'h00000, "R9 lowest address");
    read_expect(17'h1FFFF, "R9 highest address");
  endtask

  task automatic t_patterns();
    logic [7:0] r;
    logic [7:0] pat [4] = '{8'h55, 8'hAA, 8'h01, 8'h80};
    for (int i = 0; i < 4; i++) run_op(1'b1, 17'h10000 + 17'(i * 257), pat[i], r);
    for (int i = 0; i < 4; i++) read_expect(17'h10000 + 17'(i * 257), "R9 pattern readback");
    run_op(1'b1, 17'h10000, 8'h99, r);
    read_expect(17'h10000, "R9 overwrite");
  endtask

  task automatic t_idle_and_monitors();
    repeat (3) @(negedge clk);
    // R1
    chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready,
        "R1 idle pins", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    // R5
    chk(contention == 0, "R5 bus contention", contention, 0);
    // R4
    chk(addr_moves == 0, "R4 address/data moved in strobe", addr_moves, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_turnaround();
    t_boundary();
    t_patterns();
    t_idle_and_monitors();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule